// File: doc/BRIEF.md
# 1-Wire Bus Reset and Presence Detector

This block produces the reset sequence that a 1-Wire bus master sends before any transaction, and it reports whether a slave answered. When idle, a one-cycle start strobe makes it pull the open-drain data line low for a fixed reset interval. It then releases the line and samples it once, a fixed time after the release. For the rest of the recovery time it keeps the line released, and then it emits a done strobe.

All timing is counted in microseconds. A divider turns the system clock into a microsecond tick, and its ratio is set by the `CLK_PER_US` parameter. The line level passes through a two-flop synchroniser before it is sampled. The presence flag is cleared when a sequence is accepted. It is set at the sample point when the line reads low, and it then holds its value until the next accepted start.

Top module: `owr_reset_presence`

## Requirements
- R1: While reset is asserted and after it is released, `line_oe_o`, `busy_o`, `done_o` and `present_o` are all 0 until a start is accepted.
- R2: A start seen while idle sets `line_oe_o` to 1 (1 = pull the line low) from the next cycle, for exactly `LOW_US*CLK_PER_US` cycles.
- R3: The line is sampled `SAMP_US*CLK_PER_US` cycles after `line_oe_o` falls, through a two-flop synchroniser. A low sampled level makes `present_o` 1.
- R4: A high line at the sample point makes `present_o` 0. This covers no answer, an answer that begins after the sample point, and an answer that ends before it.
- R5: `busy_o` is high for exactly `(LOW_US+SAMP_US+TAIL_US)*CLK_PER_US` cycles per sequence. `done_o` is a one-cycle pulse in the cycle right after `busy_o` falls, with `busy_o` and `line_oe_o` both 0 during that pulse.
- R6: A start asserted while `busy_o` is 1 is ignored. The running sequence keeps its length, and no new sequence follows it.
- R7: `present_o` is cleared when a start is accepted. It does not change from the done pulse until the next accepted start.
- R8: A start asserted in the same cycle as `done_o` is accepted, and `busy_o` rises in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request to launch a reset sequence |
| line_i | input | 1 | Level read back from the bus data line |
| line_oe_o | output | 1 | Open-drain enable; 1 pulls the line low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence strobe |
| present_o | output | 1 | Slave answered at the sample point |

## Verification
Two events can fall in the same cycle: the done strobe that closes one sequence, and the acceptance of a new start. The bench provokes this by raising start in the exact cycle where done is seen high, so the next sequence launches with no idle gap. It then checks that busy rises in the following cycle and that the presence result of the previous sequence is cleared. Each sequence's presence result, busy length and low-pulse length are still compared against the scoreboard entry queued for it.

// File: rtl/owr_pkg.sv
package owr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_TAIL = 2'd3
  } owr_state_e;
endpackage

// File: rtl/owr_rst_sync.sv
module owr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/owr_sync2.sv
module owr_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= {2{RESET_VAL}};
    else        ff_q <= {ff_q[0], d_i};
  end

  assign q_o = ff_q[1];
endmodule

// File: rtl/owr_us_tick.sv
module owr_us_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             at_last;

  assign at_last = (div_q == DIV_LAST);

  always_comb begin
    div_d = div_q;
    if (!en_i)        div_d = '0;
    else if (at_last) div_d = '0;
    else              div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick_o = en_i && at_last;
endmodule

// File: rtl/owr_seq.sv
module owr_seq
  import owr_pkg::*;
#(
  parameter int LOW_US  = 480,
  parameter int SAMP_US = 64,
  parameter int TAIL_US = 416
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  input  logic line_s_i,
  output logic line_oe_o,
  output logic busy_o,
  output logic done_o,
  output logic present_o
);
  localparam int MAX_A  = (LOW_US > SAMP_US) ? LOW_US : SAMP_US;
  localparam int MAX_US = (MAX_A > TAIL_US) ? MAX_A : TAIL_US;
  localparam int US_W   = $clog2(MAX_US + 1);
  localparam logic [US_W-1:0] LOW_LAST  = US_W'(LOW_US - 1);
  localparam logic [US_W-1:0] SAMP_LAST = US_W'(SAMP_US - 1);
  localparam logic [US_W-1:0] TAIL_LAST = US_W'(TAIL_US - 1);

  owr_state_e      st_q, st_d;
  logic [US_W-1:0] us_q, us_d;
  logic            done_q, done_d;
  logic            pres_q, pres_d;

  always_comb begin
    st_d   = st_q;
    us_d   = us_q;
    done_d = 1'b0;
    pres_d = pres_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_LOW;
          us_d   = '0;
          pres_d = 1'b0;
        end
      end
      ST_LOW: begin
        if (tick_i) begin
          if (us_q == LOW_LAST) begin
            st_d = ST_WAIT;
            us_d = '0;
          end else begin
            us_d = us_q + 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (tick_i) begin
          if (us_q == SAMP_LAST) begin
            st_d   = ST_TAIL;
            us_d   = '0;
            pres_d = ~line_s_i;
          end else begin
            us_d = us_q + 1'b1;
          end
        end
      end
      ST_TAIL: begin
        if (tick_i) begin
          if (us_q == TAIL_LAST) begin
            st_d   = ST_IDLE;
            us_d   = '0;
            done_d = 1'b1;
          end else begin
            us_d = us_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      us_q   <= '0;
      done_q <= 1'b0;
      pres_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      us_q   <= us_d;
      done_q <= done_d;
      pres_q <= pres_d;
    end
  end

  assign line_oe_o = (st_q == ST_LOW);
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign present_o = pres_q;
endmodule

// File: rtl/owr_reset_presence.sv
module owr_reset_presence #(
  parameter int CLK_PER_US = 50,
  parameter int LOW_US     = 480,
  parameter int SAMP_US    = 64,
  parameter int TAIL_US    = 416
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic line_i,
  output logic line_oe_o,
  output logic busy_o,
  output logic done_o,
  output logic present_o
);
  logic rst_int_n;
  logic line_s;
  logic us_tick;

  owr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  owr_sync2 #(.RESET_VAL(1'b1)) u_line_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  owr_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en_i   (busy_o),
    .tick_o (us_tick)
  );

  owr_seq #(
    .LOW_US  (LOW_US),
    .SAMP_US (SAMP_US),
    .TAIL_US (TAIL_US)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start_i),
    .tick_i    (us_tick),
    .line_s_i  (line_s),
    .line_oe_o (line_oe_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .present_o (present_o)
  );
endmodule

// File: rtl/owr_reset_presence_chk.sv
module owr_reset_presence_chk #(
  parameter int CLK_PER_US = 50,
  parameter int LOW_US     = 480
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic line_oe_o,
  input logic busy_o,
  input logic done_o,
  input logic present_o
);
  logic [31:0] oe_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         oe_cnt <= '0;
    else if (line_oe_o) oe_cnt <= oe_cnt + 1;
    else                oe_cnt <= '0;
  end

  a_r2_low_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe_o |-> busy_o);

  a_r2_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe_o) |-> (oe_cnt == 32'(LOW_US * CLK_PER_US)));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !line_oe_o));

  a_r6_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

  a_r7_present_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(present_o));

  a_r8_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && line_oe_o && !present_o));
endmodule

bind owr_reset_presence owr_reset_presence_chk #(
  .CLK_PER_US (CLK_PER_US),
  .LOW_US     (LOW_US)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .start_i   (start_i),
  .line_oe_o (line_oe_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .present_o (present_o)
);

// File: tb/owr_reset_presence_tb.sv
module owr_reset_presence_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CPU  = 4;
  localparam int LOW  = 480;
  localparam int SAMP = 64;
  localparam int TAIL = 416;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic slave_pull = 1'b0;
  logic line_i;
  logic line_oe_o, busy_o, done_o, present_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit exp_q[$];
  int busy_cnt = 0;
  int oe_cnt = 0;
  logic prev_done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line_i = (line_oe_o || slave_pull) ? 1'b0 : 1'b1;

  owr_reset_presence #(.CLK_PER_US(CPU)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .line_i    (line_i),
    .line_oe_o (line_oe_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .present_o (present_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor / scoreboard consumer
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o)    busy_cnt++;
      if (line_oe_o) oe_cnt++;
      if (done_o && prev_done) chk("R5 done width", 2, 1);
      if (done_o) begin
        if (exp_q.size() == 0) chk("R6 unexpected done", 1, 0);
        else chk("R3/R4 presence", int'(present_o), int'(exp_q.pop_front()));
        chk("R5 busy length", busy_cnt, (LOW + SAMP + TAIL) * CPU);
        chk("R2 low length", oe_cnt, LOW * CPU);
        chk("R5 busy in done cycle", int'(busy_o), 0);
        busy_cnt = 0;
        oe_cnt   = 0;
      end
      prev_done = done_o;
    end
  end

  task automatic slave_run(int dly, int len);
    if (len == 0) return;
    @(negedge line_oe_o);
    repeat (dly * CPU) @(posedge clk);
    slave_pull = 1'b1;
    repeat (len * CPU) @(posedge clk);
    slave_pull = 1'b0;
  endtask

  task automatic launch(bit exp, int dly, int len);
    exp_q.push_back(exp);
    fork slave_run(dly, len); join_none
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done_o);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000 - 50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 oe in reset", int'(line_oe_o), 0);
    chk("R1 busy in reset", int'(busy_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 oe after reset", int'(line_oe_o), 0);
    chk("R1 busy after reset", int'(busy_o), 0);
    chk("R1 done after reset", int'(done_o), 0);
    chk("R1 present after reset", int'(present_o), 0);

    // R3: slave answers 30 us after release for 120 us
    launch(1'b1, 30, 120);
    chk("R2 oe after start", int'(line_oe_o), 1);
    wait_done();
    // R7: hold after done
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk("R7 present held", int'(present_o), 1);
    end

    // R4: no slave
    launch(1'b0, 0, 0);
    chk("R7 present cleared on start", int'(present_o), 0);
    wait_done();
    // R4: answer starts after sample point
    launch(1'b0, 70, 100);
    wait_done();
    // R4: answer ends before sample point
    launch(1'b0, 10, 40);
    wait_done();

    // R6: start while busy ignored
    launch(1'b1, 20, 100);
    repeat (200 * CPU) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    wait_done();
    repeat (5) begin
      @(negedge clk);
      chk("R6 no relaunch", int'(busy_o), 0);
    end

    // R8: start coincident with done
    launch(1'b1, 30, 120);
    wait_done();
    exp_q.push_back(1'b0);
    start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk("R8 busy after coincident start", int'(busy_o), 1);
    repeat (10 * CPU) @(negedge clk);
    chk("R7 present cleared after back-to-back", int'(present_o), 0);
    wait_done();
    repeat (5) @(negedge clk);
    chk("R6 scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule